// File: doc/BRIEF.md
# Multi-Format Serial PCM Audio Receiver

This block turns a two-channel serial PCM stream into a parallel left/right sample pair. It runs entirely in the bit-clock domain: every rising edge of the bit clock samples the word-select (LR) clock and the data line or lines. A change of the LR clock opens a new channel slot. While the LR clock is high the slot carries the left channel, and while it is low the slot carries the right channel.

Three framings are supported. The first puts both channels on one line, right-justified, with a selectable word length of 16, 18, 20 or 24 bits. The second also uses one line but carries 24-bit left-justified words. The third carries both channels at the same time on two separate lines, as 24-bit left-justified words. Every sample, whatever its length, is presented as a 24-bit two's-complement value. A single-cycle strobe marks each new pair, and both channels of the pair change together in the same cycle.

The format and word-length selects are static configuration. They are changed only while the block is held in reset. The reset input is asserted asynchronously and released through a two-stage synchronizer on the bit clock.

Top module: `pcm_rx_multi`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair is delivered, `pcm_left` and `pcm_right` are zero and `pcm_valid` is low.
- R2: Data and the LR clock are sampled on the rising edge of `bck`. A slot boundary is the first rising edge at which `lrck` differs from its previously sampled value. High means the left channel and low means the right channel. Samples are two's complement and arrive MSB first.
- R3: With `fmt_sel` = 00 (right-justified, single line `sdata`), the sample is the last N bits sampled before the boundary that ends the slot. N is 16, 18, 20 or 24 for `wlen_sel` = 00, 01, 10 or 11. Earlier bits of the slot are ignored, and the sample is sign-extended to 24 bits.
- R4: With `fmt_sel` = 01 (left-justified, single line `sdata`), the sample is the first 24 bits of the slot, starting with the bit sampled at the boundary that opens it. Later bits of the slot are ignored.
- R5: In the left-justified formats, a slot shorter than 24 bits yields its bits left-aligned, with the missing low bits set to zero.
- R6: With `fmt_sel` = 10 or 11 (two lines), the left word is the first 24 bits on `sdata_l` and the right word is the first 24 bits on `sdata_r`, both counted from the boundary where `lrck` rises. Data sampled while `lrck` is low is ignored. The pair is delivered after the first rising edge that samples `lrck` low.
- R7: In the single-line formats, a pair is delivered after the rising edge that samples `lrck` high again, which ends the right slot. Delivery requires that the left slot of the same frame was captured.
- R8: `pcm_valid` is high for exactly one cycle per delivered pair. `pcm_left` and `pcm_right` change only in the cycle where `pcm_valid` is high.
- R9: The first boundary after reset only starts framing. A slot that was already under way when reset was released is never reported, and neither is a frame whose left slot was missed.
- R10: `wlen_sel` has no effect in the left-justified formats.
- R11: The line unused by the selected format has no effect: `sdata_l` and `sdata_r` are ignored in the single-line formats, and `sdata` is ignored in the two-line format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word-select clock; high = left slot, low = right slot |
| sdata | input | 1 | Shared serial data line for the single-line formats |
| sdata_l | input | 1 | Left-channel data line for the two-line format |
| sdata_r | input | 1 | Right-channel data line for the two-line format |
| fmt_sel | input | 2 | 00 right-justified, 01 left-justified, 10/11 two-line left-justified |
| wlen_sel | input | 2 | Right-justified word length: 00=16, 01=18, 10=20, 11=24 |
| pcm_left | output | SAMPLE_W | Left sample, 24-bit signed |
| pcm_right | output | SAMPLE_W | Right sample, 24-bit signed |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The embedded assertions check, on every cycle, the properties that hold regardless of the data: the strobe lasts one cycle, the outputs hold still between strobes, each strobe follows the correct kind of LR boundary for the active format, the framing latch never drops once set, the left-justified fill counter stays within range, and 16-bit right-justified results are properly sign-extended. Whether the right bits were actually picked can be shown only by the bench's scenarios. These scenarios cover padded and exactly sized right-justified slots, junk bits after left-justified words, short slots, random data on unused lines, a partial slot at start-up, and the cycle in which each pair appears.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int WORD_W = 24;

  // Format select encodings
  localparam logic [1:0] FMT_RJ = 2'b00;
  localparam logic [1:0] FMT_LJ = 2'b01;

  function automatic logic fmt_is_dual(input logic [1:0] fmt);
    return fmt[1];
  endfunction

  function automatic logic fmt_is_rj(input logic [1:0] fmt);
    return fmt == FMT_RJ;
  endfunction

  // Right-justified word length for each select code
  function automatic int rj_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sar_slot_track.sv
module sar_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  output logic boundary,
  output logic rise,
  output logic fall,
  output logic framed
);
  logic lr_q, lr_d;
  logic seen_q, seen_d;
  logic open_q, open_d;

  assign boundary = seen_q && (lrck != lr_q);
  assign rise     = boundary && lrck;
  assign fall     = boundary && !lrck;
  assign framed   = open_q;

  always_comb begin
    lr_d   = lrck;
    seen_d = 1'b1;
    open_d = open_q | boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      seen_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      lr_q   <= lr_d;
      seen_q <= seen_d;
      open_q <= open_d;
    end
  end

  // R9: once framing has started it stays started until reset
  assert_framed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q);

endmodule

// File: rtl/sar_lane.sv
module sar_lane #(
  parameter int W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_in,
  input  logic                       start,
  input  logic                       free_run,
  output logic [W-1:0]               shreg,
  output logic [$clog2(W+1)-1:0]     fill
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          shift_en;

  assign shift_en = free_run | start | (fill_q < FULL);

  always_comb begin
    sr_d   = sr_q;
    fill_d = fill_q;
    if (shift_en) sr_d = {sr_q[W-2:0], bit_in};
    if (start)               fill_d = CW'(1);
    else if (fill_q < FULL)  fill_d = fill_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end

  assign shreg = sr_q;
  assign fill  = fill_q;

  // R5: the fill count never passes the word width
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);

endmodule

// File: rtl/sar_align.sv
module sar_align #(
  parameter int W = 24
) (
  input  logic [W-1:0]           shreg,
  input  logic [$clog2(W+1)-1:0] fill,
  input  logic                   rj,
  input  logic [1:0]             wlen,
  output logic [W-1:0]           word
);
  import sar_pkg::*;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  int n;

  always_comb begin
    n    = rj_len(wlen);
    word = '0;
    if (rj) begin
      for (int i = 0; i < W; i++) word[i] = (i < n) ? shreg[i] : shreg[n-1];
    end else begin
      word = shreg << (FULL - fill);
    end
  end
endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         framed,
  input  logic         dual,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         out_valid
);
  logic [W-1:0] hold_q, hold_d;
  logic         have_q, have_d;
  logic [W-1:0] l_q, l_d, r_q, r_d;
  logic         v_q, v_d;

  always_comb begin
    hold_d = hold_q;
    have_d = have_q;
    l_d    = l_q;
    r_d    = r_q;
    v_d    = 1'b0;
    if (framed) begin
      if (dual) begin
        if (fall) begin
          l_d = word_a;
          r_d = word_b;
          v_d = 1'b1;
        end
      end else if (fall) begin
        hold_d = word_a;
        have_d = 1'b1;
      end else if (rise && have_q) begin
        l_d    = hold_q;
        r_d    = word_a;
        v_d    = 1'b1;
        have_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
      v_q    <= 1'b0;
    end else begin
      hold_q <= hold_d;
      have_q <= have_d;
      l_q    <= l_d;
      r_q    <= r_d;
      v_q    <= v_d;
    end
  end

  assign out_left  = l_q;
  assign out_right = r_q;
  assign out_valid = v_q;

  // R8: strobe lasts a single cycle
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> !v_q);

  // R8: pair changes only together with the strobe
  assert_pair_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> ($stable(l_q) && $stable(r_q)));

  // R7: single-line delivery follows an LR rising boundary
  assert_single_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !dual) |-> $past(rise));

  // R6: two-line delivery follows an LR falling boundary
  assert_dual_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && dual) |-> $past(fall));

endmodule

// File: rtl/pcm_rx_multi.sv
module pcm_rx_multi #(
  parameter int SAMPLE_W = sar_pkg::WORD_W
) (
  input  logic                bck,
  input  logic                rst_n,
  input  logic                lrck,
  input  logic                sdata,
  input  logic                sdata_l,
  input  logic                sdata_r,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic                pcm_valid
);
  import sar_pkg::*;
  localparam int LANES = 2;
  localparam int CW    = $clog2(SAMPLE_W + 1);

  logic rst_n_s;
  logic boundary, rise, fall, framed;
  logic dual, rj;

  logic [LANES-1:0]    lane_bit;
  logic [SAMPLE_W-1:0] lane_sr   [LANES];
  logic [CW-1:0]       lane_fill [LANES];
  logic [SAMPLE_W-1:0] lane_word [LANES];

  assign dual = fmt_is_dual(fmt_sel);
  assign rj   = fmt_is_rj(fmt_sel);

  assign lane_bit[0] = dual ? sdata_l : sdata;
  assign lane_bit[1] = sdata_r;

  sar_rst_sync u_rst (
    .clk        (bck),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sar_slot_track u_track (
    .clk      (bck),
    .rst_n    (rst_n_s),
    .lrck     (lrck),
    .boundary (boundary),
    .rise     (rise),
    .fall     (fall),
    .framed   (framed)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sar_lane #(.W(SAMPLE_W)) u_lane (
      .clk      (bck),
      .rst_n    (rst_n_s),
      .bit_in   (lane_bit[g]),
      .start    (boundary),
      .free_run (rj),
      .shreg    (lane_sr[g]),
      .fill     (lane_fill[g])
    );

    sar_align #(.W(SAMPLE_W)) u_align (
      .shreg (lane_sr[g]),
      .fill  (lane_fill[g]),
      .rj    (rj),
      .wlen  (wlen_sel),
      .word  (lane_word[g])
    );
  end

  sar_pair_out #(.W(SAMPLE_W)) u_pair (
    .clk       (bck),
    .rst_n     (rst_n_s),
    .rise      (rise),
    .fall      (fall),
    .framed    (framed),
    .dual      (dual),
    .word_a    (lane_word[0]),
    .word_b    (lane_word[1]),
    .out_left  (pcm_left),
    .out_right (pcm_right),
    .out_valid (pcm_valid)
  );

  // R3: 16-bit right-justified words come out sign-extended
  assert_sign_ext16_R3: assert property (@(posedge bck) disable iff (!rst_n_s)
    (pcm_valid && fmt_sel == 2'b00 && wlen_sel == 2'b00) |->
      (pcm_left[SAMPLE_W-1:15] == {(SAMPLE_W-15){pcm_left[15]}} &&
       pcm_right[SAMPLE_W-1:15] == {(SAMPLE_W-15){pcm_right[15]}}));

endmodule

// File: tb/test_pcm_rx_multi.sv
module test_pcm_rx_multi;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        bck = 1'b0;
  logic        rst_n;
  logic        lrck, sdata, sdata_l, sdata_r;
  logic [1:0]  fmt_sel, wlen_sel;
  logic [23:0] pcm_left, pcm_right;
  logic        pcm_valid;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  bit    pend_v;
  logic [23:0] pend_l, pend_r, last_l, last_r;
  string cur_req;

  always #(CLK_PERIOD/2) bck = ~bck;

  pcm_rx_multi i_pcm_rx_multi (
    .bck(bck), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
    .sdata_l(sdata_l), .sdata_r(sdata_r), .fmt_sel(fmt_sel),
    .wlen_sel(wlen_sel), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_valid(pcm_valid)
  );

  function automatic logic rnd();
    return logic'($urandom() & 1);
  endfunction

  function automatic int wlen_bits(input logic [1:0] s);
    case (s)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  // Serial bit i of a slot of 'slot' bits for the single-line formats
  function automatic logic ser_bit(input logic [23:0] v, input int i, input int slot);
    int n, lead;
    if (fmt_sel == 2'b00) begin
      n = wlen_bits(wlen_sel);
      lead = slot - n;
      if (i < lead) return rnd();
      return v[n-1-(i-lead)];
    end
    if (i < 24) return v[23-i];
    return rnd();
  endfunction

  function automatic logic lj_bit(input logic [23:0] v, input int i);
    if (i < 24) return v[23-i];
    return rnd();
  endfunction

  function automatic logic [23:0] expv(input logic [23:0] v, input int slot);
    logic [23:0] r;
    int n;
    r = v;
    if (fmt_sel == 2'b00) begin
      n = wlen_bits(wlen_sel);
      for (int k = 0; k < 24; k++) r[k] = (k < n) ? v[k] : v[n-1];
    end else if (slot < 24) begin
      for (int k = 0; k < 24 - slot; k++) r[k] = 1'b0;
    end
    return r;
  endfunction

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Drive one bit at a falling edge, then check at the next falling edge
  task automatic drive(input logic lr, input logic d, input logic dl, input logic dr,
                       input bit expect_v, input logic [23:0] el, input logic [23:0] er);
    lrck = lr; sdata = d; sdata_l = dl; sdata_r = dr;
    @(posedge bck);
    @(negedge bck);
    if (expect_v) begin
      n_chk++;
      if (pcm_valid !== 1'b1 || pcm_left !== el || pcm_right !== er) begin
        n_fail++;
        $display("FAIL %s: valid=%b L=%h R=%h expected valid=1 L=%h R=%h",
                 cur_req, pcm_valid, pcm_left, pcm_right, el, er);
      end
      last_l = el; last_r = er;
    end else if (pcm_valid !== 1'b0 || pcm_left !== last_l || pcm_right !== last_r) begin
      n_chk++; n_fail++;
      $display("FAIL R8 (%s): valid=%b L=%h R=%h expected valid=0 L=%h R=%h",
               cur_req, pcm_valid, pcm_left, pcm_right, last_l, last_r);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w, input bit start_hi);
    rst_n = 1'b0; lrck = 1'b0; sdata = 1'b0; sdata_l = 1'b0; sdata_r = 1'b0;
    fmt_sel = f; wlen_sel = w;
    repeat (3) @(negedge bck);
    n_chk++;  // R1: reset state
    if (pcm_valid !== 1'b0 || pcm_left !== 24'h0 || pcm_right !== 24'h0) begin
      n_fail++;
      $display("FAIL R1: valid=%b L=%h R=%h expected 0/000000/000000",
               pcm_valid, pcm_left, pcm_right);
    end
    rst_n = 1'b1;
    last_l = '0; last_r = '0; pend_v = 1'b0;
    for (int i = 0; i < 6; i++) drive(start_hi, rnd(), rnd(), rnd(), 0, '0, '0);
    if (start_hi) begin
      // R9: partial left slot then a full right slot: nothing may be reported
      for (int i = 0; i < 32; i++) drive(1'b0, rnd(), rnd(), rnd(), 0, '0, '0);
    end
  endtask

  task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv,
                            input int sh, input int sl);
    if (!fmt_sel[1]) begin
      for (int i = 0; i < sh; i++) begin
        drive(1'b1, ser_bit(lv, i, sh), rnd(), rnd(), (i == 0) && pend_v, pend_l, pend_r);
        if (i == 0) pend_v = 1'b0;
      end
      for (int i = 0; i < sl; i++) drive(1'b0, ser_bit(rv, i, sl), rnd(), rnd(), 0, '0, '0);
      pend_v = 1'b1; pend_l = expv(lv, sh); pend_r = expv(rv, sl);
    end else begin
      for (int i = 0; i < sh; i++) drive(1'b1, rnd(), lj_bit(lv, i), lj_bit(rv, i), 0, '0, '0);
      for (int i = 0; i < sl; i++)
        drive(1'b0, rnd(), rnd(), rnd(), i == 0, expv(lv, sh), expv(rv, sh));
    end
  endtask

  task automatic flush();
    drive(1'b1, rnd(), rnd(), rnd(), pend_v, pend_l, pend_r);
    pend_v = 1'b0;
    for (int i = 0; i < 4; i++) drive(1'b1, rnd(), rnd(), rnd(), 0, '0, '0);
  endtask

  task automatic run_random(input int frames, input int sh, input int sl);
    for (int k = 0; k < frames; k++)
      send_frame(24'($urandom()), 24'($urandom()), sh, sl);
  endtask

  initial begin
    void'($urandom(32'h5A17_C0DE));

    // R3: right-justified, 16 bits, padded slots, signed extremes first
    cur_req = "R3 R2 R7";
    do_reset(2'b00, 2'b00, 1'b0);
    send_frame(24'hAB7FFF, 24'h128000, 32, 32);
    send_frame(24'h00FFFF, 24'hFF0001, 32, 32);
    run_random(6, 32, 32);
    flush();

    // R3: 18-bit and 20-bit words, 20-bit with a slot exactly 20 bits long
    do_reset(2'b00, 2'b01, 1'b0);
    send_frame(24'h020000, 24'h01FFFF, 32, 32);
    run_random(5, 32, 32);
    flush();
    do_reset(2'b00, 2'b10, 1'b0);
    send_frame(24'h080000, 24'h07FFFF, 20, 20);
    run_random(5, 20, 24);
    flush();

    // R3: 24-bit words, exact and padded slots
    do_reset(2'b00, 2'b11, 1'b0);
    send_frame(24'h800000, 24'h7FFFFF, 24, 24);
    run_random(4, 24, 32);
    flush();

    // R9: start-up inside a left slot
    cur_req = "R9 R3";
    do_reset(2'b00, 2'b00, 1'b1);
    run_random(4, 32, 32);
    flush();

    // R4 and R10: left-justified, junk bits after the word, random word-length select
    cur_req = "R4 R10 R11";
    do_reset(2'b01, 2'($urandom()), 1'b0);
    send_frame(24'h800001, 24'h7FFFFE, 32, 32);
    run_random(6, 32, 32);
    flush();
    do_reset(2'b01, 2'b00, 1'b0);
    run_random(4, 24, 32);
    flush();

    // R5: short left-justified slots
    cur_req = "R5 R4";
    do_reset(2'b01, 2'b11, 1'b0);
    send_frame(24'hFFFFFF, 24'hA5A5A5, 20, 16);
    run_random(4, 20, 18);
    flush();

    // R6 and R11: two-line format, both select codes
    cur_req = "R6 R11";
    do_reset(2'b10, 2'($urandom()), 1'b0);
    send_frame(24'h800000, 24'h7FFFFF, 32, 32);
    run_random(6, 32, 32);
    flush();
    do_reset(2'b11, 2'b00, 1'b0);
    run_random(4, 24, 8);
    flush();

    // R5 in the two-line format
    cur_req = "R5 R6";
    do_reset(2'b10, 2'b01, 1'b0);
    run_random(4, 18, 20);
    flush();

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge bck);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion within %0d cycles",
               WATCHDOG);
      report();
      $finish;
    end
  end

endmodule